// File: doc/BRIEF.md
# Conversion Result Byte Serializer

This block takes 16-bit conversion results from a sample pipeline and places them on a narrow 8-bit output bus. A result is captured when the sample strobe is high. It then passes through a fixed-depth delay line that models the converter's pipeline latency, and is handed to an output stage.

In two-byte mode the output stage shows the upper byte of each result for one cycle and the lower byte in the following cycle. A phase output tells the reader which half is currently on the bus. In single-byte mode only the upper byte of each result is shown, and a new result can be taken every cycle. An active-low output enable releases the bus without pausing the flow of results.

A result that becomes ready while an upper byte is on the bus waits in a one-entry hold register. This keeps a byte pair from being split. The source must arrange its strobes so that no more than one result is ever waiting.

Top module: `adc_byte_mux`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `dataValid` is 0 and `bytePhase` is 0.
- R2: If the output stage is idle, a result strobed at a rising edge appears on the bus, valid and in high phase, right after the LATENCY-th rising edge. The strobing edge counts as the first of these edges.
- R3: In two-byte mode (`singleByte`=0), a result occupies two consecutive valid cycles. In the first, `bytePhase`=0 and the bus carries result bits 15:8. In the second, `bytePhase`=1 and the bus carries bits 7:0. A low-phase cycle is never followed directly by another low-phase cycle.
- R4: Bus bit 7 carries the most significant bit of the byte being shown, and bus bit 0 carries the least significant bit. For example, result 16'h8001 gives bus 8'h80 in high phase and 8'h01 in low phase.
- R5: In single-byte mode (`singleByte`=1), every valid cycle shows bits 15:8 of one result with `bytePhase`=0. Results strobed on consecutive cycles appear on consecutive cycles, in the order they were strobed.
- R6: A result that becomes ready while a high byte is shown in two-byte mode is held. It appears in high phase in the cycle after the low byte, and results keep their strobe order. One result can be held at a time. The source must not let a second result become ready while one is held and a high byte is shown.
- R7: When `outEnN` is 1, `busDrive` is 0 and `dataOut` is released to high impedance. When `outEnN` is 0, `busDrive` is 1. The output enable has no effect on the order or timing of the byte sequence.
- R8: If `singleByte` is 1 at the edge that would advance a shown high byte to its low byte, the low byte is skipped. The stage takes the next ready result, or goes idle if none is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | Captures `sampleWord` into the delay line at the rising edge |
| sampleWord | input | 16 | Conversion result |
| singleByte | input | 1 | 1 selects high-byte-only output, 0 selects two-byte output |
| outEnN | input | 1 | Output enable, active low |
| dataOut | output | 8 | Byte bus, high impedance while `outEnN` is 1 |
| busDrive | output | 1 | 1 while the block drives `dataOut` |
| dataValid | output | 1 | A result byte is on the bus |
| bytePhase | output | 1 | 0 for the upper byte, 1 for the lower byte |

## Verification
The bench builds the block with its default values: an 8-bit bus and a latency of 9. With these values up to nine results can be in flight at once. A run of single-byte strobes therefore fills the entire delay line, and the exact edge on which the first byte appears can be counted against a depth that is not trivially short. Back-to-back strobe pairs in two-byte mode, mode changes while a high byte is shown, and a toggling output enable are all compared cycle by cycle with a queue-based model.

// File: rtl/adc_byte_mux_pkg.sv
package adc_byte_mux_pkg;

  // Strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic loadPend;   // output word <- hold register
    logic loadTail;   // output word <- delay-line tail
    logic stashTail;  // hold register <- delay-line tail
    logic showLow;    // select the lower byte onto the bus
  } muxStrobe_t;

endpackage

// File: rtl/adc_byte_mux_ctrl.sv
module adc_byte_mux_ctrl
  import adc_byte_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       singleByte,
  input  logic       tailValid,
  output muxStrobe_t strobe,
  output logic       outValid,
  output logic       pendFull
);

  logic validQ, phaseQ, pendQ;
  logic validD, phaseD, pendD;
  logic holdHigh;

  always_comb begin
    holdHigh = validQ && !phaseQ && !singleByte;
    strobe = '0;
    strobe.showLow = phaseQ;
    validD = 1'b0;
    phaseD = 1'b0;
    pendD  = 1'b0;
    if (holdHigh) begin
      // pair in progress: advance to the low byte, park any arrival
      validD = 1'b1;
      phaseD = 1'b1;
      pendD  = pendQ | tailValid;
      strobe.stashTail = tailValid && !pendQ;
    end else if (pendQ) begin
      // parked result goes first, a new arrival takes its place
      strobe.loadPend  = 1'b1;
      strobe.stashTail = tailValid;
      validD = 1'b1;
      pendD  = tailValid;
    end else if (tailValid) begin
      strobe.loadTail = 1'b1;
      validD = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      phaseQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      validQ <= validD;
      phaseQ <= phaseD;
      pendQ  <= pendD;
    end
  end

  assign outValid = validQ;
  assign pendFull = pendQ;

endmodule

// File: rtl/adc_byte_mux_dp.sv
module adc_byte_mux_dp
  import adc_byte_mux_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int LATENCY = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleStb,
  input  logic [2*BYTE_W-1:0]   sampleWord,
  input  muxStrobe_t            strobe,
  output logic                  tailValid,
  output logic [BYTE_W-1:0]     curByte
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int STAGES = LATENCY - 1;  // output register adds the last edge

  // each stage: {valid, word}
  logic [WORD_W:0]   line [STAGES];
  logic [WORD_W-1:0] outWord, pendWord;
  logic [WORD_W-1:0] tailWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) line[i] <= '0;
    end else begin
      line[0] <= {sampleStb, sampleWord};
      for (int i = 1; i < STAGES; i++) line[i] <= line[i-1];
    end
  end

  assign tailValid = line[STAGES-1][WORD_W];
  assign tailWord  = line[STAGES-1][WORD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord  <= '0;
      pendWord <= '0;
    end else begin
      if (strobe.loadPend)      outWord <= pendWord;
      else if (strobe.loadTail) outWord <= tailWord;
      if (strobe.stashTail)     pendWord <= tailWord;
    end
  end

  generate
    if (BYTE_W == 1) begin : g_bitBus
      assign curByte = strobe.showLow ? outWord[0] : outWord[1];
    end else begin : g_byteBus
      assign curByte = strobe.showLow ? outWord[BYTE_W-1:0]
                                      : outWord[WORD_W-1:BYTE_W];
    end
  endgenerate

endmodule

// File: rtl/adc_byte_mux.sv
module adc_byte_mux
  import adc_byte_mux_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int LATENCY = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleStb,
  input  logic [2*BYTE_W-1:0]   sampleWord,
  input  logic                  singleByte,
  input  logic                  outEnN,
  output logic [BYTE_W-1:0]     dataOut,
  output logic                  busDrive,
  output logic                  dataValid,
  output logic                  bytePhase
);

  muxStrobe_t        strobe;
  logic              tailValid;
  logic              pendFull;
  logic [BYTE_W-1:0] curByte;

  adc_byte_mux_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .singleByte (singleByte),
    .tailValid  (tailValid),
    .strobe     (strobe),
    .outValid   (dataValid),
    .pendFull   (pendFull)
  );

  adc_byte_mux_dp #(.BYTE_W(BYTE_W), .LATENCY(LATENCY)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleStb  (sampleStb),
    .sampleWord (sampleWord),
    .strobe     (strobe),
    .tailValid  (tailValid),
    .curByte    (curByte)
  );

  assign busDrive  = !outEnN;
  assign bytePhase = strobe.showLow;
  assign dataOut   = busDrive ? curByte : 'z;

endmodule

// File: rtl/adc_byte_mux_chk.sv
module adc_byte_mux_chk (
  input logic clk,
  input logic rstN,
  input logic singleByte,
  input logic dataValid,
  input logic bytePhase,
  input logic pendFull,
  input logic tailValid
);

  // R3: a high byte in two-byte mode is followed by its low byte
  p_low_after_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && !bytePhase && !singleByte |=> dataValid && bytePhase);

  // R3: low phase only while valid, and never twice in a row
  p_phase_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    bytePhase |-> dataValid);
  p_low_ends_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && bytePhase |=> !bytePhase);

  // R5 / R8: single-byte mode never advances to a low byte
  p_single_high_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    singleByte |=> !bytePhase);

  // R6: a held result is shown next cycle or the pair is finishing
  p_held_progress_r6: assert property (@(posedge clk) disable iff (!rstN)
    pendFull |=> dataValid);

  // R6: hold register is never asked to take a second result
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && !bytePhase && !singleByte && pendFull |-> !tailValid);

endmodule

bind adc_byte_mux adc_byte_mux_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .singleByte (singleByte),
  .dataValid  (dataValid),
  .bytePhase  (bytePhase),
  .pendFull   (pendFull),
  .tailValid  (tailValid)
);

// File: tb/adc_byte_mux_bench.sv
module adc_byte_mux_bench;

  localparam int LAT = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStb = 1'b0;
  logic [15:0] sampleWord = '0;
  logic        singleByte = 1'b0;
  logic        outEnN = 1'b0;
  wire  [7:0]  dataOut;
  logic        busDrive, dataValid, bytePhase;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  adc_byte_mux #(.BYTE_W(8), .LATENCY(LAT)) u_adc_byte_mux (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .sampleWord(sampleWord),
    .singleByte(singleByte), .outEnN(outEnN), .dataOut(dataOut),
    .busDrive(busDrive), .dataValid(dataValid), .bytePhase(bytePhase)
  );

  // behavioural reference
  typedef struct { int ready; logic [15:0] w; } item_t;
  item_t       q[$];
  int          edgeNo = 0;
  logic        expValid = 1'b0;
  logic        expPhase = 1'b0;
  logic [15:0] expWord  = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, advance model for the coming edge, compare at next negedge
  task automatic step(input logic stb, input logic [15:0] w, input logic single,
                      input logic oeN, input string tag);
    logic [7:0] expByte;
    item_t it;
    sampleStb = stb; sampleWord = w; singleByte = single; outEnN = oeN;
    edgeNo++;
    if (stb) begin
      it.ready = edgeNo + LAT - 1;
      it.w = w;
      q.push_back(it);
    end
    if (expValid && !expPhase && !single) begin
      expPhase = 1'b1;
    end else if (q.size() > 0 && q[0].ready <= edgeNo) begin
      it = q.pop_front();
      expWord = it.w; expValid = 1'b1; expPhase = 1'b0;
    end else begin
      expValid = 1'b0; expPhase = 1'b0;
    end
    @(negedge clk);
    expByte = expPhase ? expWord[7:0] : expWord[15:8];
    check(dataValid === expValid && bytePhase === expPhase, tag, "valid/phase",
          {dataValid, bytePhase}, {expValid, expPhase});
    check(busDrive === !oeN, "R7", "busDrive", busDrive, !oeN);
    if (expValid && !oeN)
      check(dataOut === expByte, tag, "dataOut", dataOut, expByte);
  endtask

  task automatic idle(input int n, input logic single, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, single, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dataValid === 1'b0, "R1", "dataValid in reset", dataValid, 0);
    check(bytePhase === 1'b0, "R1", "bytePhase in reset", bytePhase, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(dataValid === 1'b0 && bytePhase === 1'b0, "R1", "after release",
          {dataValid, bytePhase}, 0);

    // R2: latency of a lone result, R4: bit order with 16'h8001
    begin
      int seen = 0;
      step(1'b1, 16'h8001, 1'b0, 1'b0, "R2");
      if (dataValid) seen = 1;
      for (int i = 2; i <= LAT + 4; i++) begin
        step(1'b0, 16'h0, 1'b0, 1'b0, "R4");
        if (dataValid && seen == 0) seen = i;
        if (dataValid && !bytePhase)
          check(dataOut === 8'h80, "R4", "high byte of 8001", dataOut, 8'h80);
        if (dataValid && bytePhase)
          check(dataOut === 8'h01, "R4", "low byte of 8001", dataOut, 8'h01);
      end
      check(seen == LAT, "R2", "first valid step", seen, LAT);
    end

    // R3: spaced results in two-byte mode
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 16'h1234 + 16'(i * 16'h1111), 1'b0, 1'b0, "R3");
      step(1'b0, 16'h0, 1'b0, 1'b0, "R3");
    end
    idle(LAT + 3, 1'b0, "R3");

    // R5: single-byte burst, one result per cycle, fills the delay line
    for (int i = 0; i < 12; i++)
      step(1'b1, 16'hC300 + 16'(i * 16'h0101), 1'b1, 1'b0, "R5");
    idle(LAT + 3, 1'b1, "R5");

    // R6: back-to-back pairs in two-byte mode, second result waits
    for (int r = 0; r < 3; r++) begin
      step(1'b1, 16'hA000 + 16'(r), 1'b0, 1'b0, "R6");
      step(1'b1, 16'h5B00 + 16'(r), 1'b0, 1'b0, "R6");
      step(1'b0, 16'h0, 1'b0, 1'b0, "R6");
      step(1'b0, 16'h0, 1'b0, 1'b0, "R6");
    end
    idle(LAT + 4, 1'b0, "R6");

    // R7: output enable toggling while results flow
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 16'h7E00 + 16'(i), 1'b0, (i % 3) == 0, "R7");
      step(1'b0, 16'h0, 1'b0, (i % 2) == 0, "R7");
    end
    for (int i = 0; i < LAT + 3; i++)
      step(1'b0, 16'h0, 1'b0, (i % 2) == 1, "R7");

    // R8: switch to single-byte while a high byte is shown
    step(1'b1, 16'hBEEF, 1'b0, 1'b0, "R8");
    while (!dataValid && vectors < 100000) step(1'b0, 16'h0, 1'b0, 1'b0, "R8");
    step(1'b0, 16'h0, 1'b1, 1'b0, "R8");
    check(dataValid === 1'b0 && bytePhase === 1'b0, "R8", "low byte skipped",
          {dataValid, bytePhase}, 0);
    idle(4, 1'b0, "R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule